// File: doc/BRIEF.md
# Scan Pattern Sequencer with Selectable Launch Modes

This block wraps a small group of state flip-flops and their combinational next-state logic so that they can be tested through scan. Every flip-flop is a mux-D scan cell. The cells are grouped into two chains of three cells each. The chains run in tandem and share one scan-enable. Each chain has its own serial input and serial output, and these ports stand for the tester's channels.

A sequencer runs one whole test pattern per start request. First it loads the chains. Then it performs the capture step that the selected mode calls for, and finally it unloads the response. The modes are:

- a single stuck-at capture;
- a launch-off-shift transition test;
- a launch-off-capture transition test;
- a no-capture pattern for quiescent-current measurement.

A done pulse follows the last unload cycle. A start raised together with that pulse begins the next pattern at once. In that case the unload just finished has already shifted in the next pattern's initial vector, so no separate load is needed. With test mode low, the cells behave as plain registers.

Top module: `scan_seq`

## Requirements
- R1: After reset, `state_q` is all zeros and `scan_en` and `done` are low.
- R2: While `test_mode` is low, `scan_en` stays low, `start` has no effect, `done` stays low and the cells load their next state on every clock. The cells are numbered i = 0..5: chain 0 is cells 0 to 2 and chain 1 is cells 3 to 5. The next value of cell i is cell[(i+5) mod 6] XOR cell[(i+2) mod 6], and `func_in` is also XORed into cell 0.
- R3: On a clock with `scan_en` high, cell 0 takes `scan_in[0]`, cell 1 takes cell 0 and cell 2 takes cell 1. Cells 3, 4 and 5 do the same from `scan_in[1]`. `scan_out[0]` shows cell 2 and `scan_out[1]` shows cell 5. A start from idle is followed by three load cycles with `scan_en` high.
- R4: Mode 2'b00 (stuck-at) gives exactly one capture cycle with `scan_en` low, straight after the load.
- R5: Mode 2'b01 (launch-off-shift) gives one extra shift cycle with `scan_en` high, which produces V2. A capture cycle with `scan_en` low follows immediately.
- R6: Mode 2'b10 (launch-off-capture) gives two functional cycles with `scan_en` low. The first loads V2 as the next state of V1, and the second captures the response.
- R7: Mode 2'b11 (no-capture) goes straight from the load to the unload, so the unloaded bits equal the loaded vector.
- R8: `mode` is sampled only in the cycle in which a start is accepted. Later changes to it do not affect the running pattern.
- R9: The unload lasts three cycles with `scan_en` high. `done` is then high for exactly one cycle. During that cycle, and in idle, the cells hold their value.
- R10: A start accepted while `done` is high skips the load. The vector shifted in during the unload serves as V1 and the mode step begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | High selects scan test operation |
| start | input | 1 | Request to run one pattern |
| mode | input | 2 | Pattern kind: 00 stuck-at, 01 launch-off-shift, 10 launch-off-capture, 11 no-capture |
| scan_in | input | 2 | Serial input of each chain |
| func_in | input | 1 | Primary input feeding the next-state logic |
| scan_out | output | 2 | Serial output of each chain (its last cell) |
| scan_en | output | 1 | Shared scan enable |
| done | output | 1 | One-cycle pulse after the last unload cycle |
| state_q | output | 6 | Present contents of the six cells |

## Verification
The sequence starts at the clock edge that accepts a start. From idle, the loaded vector appears on `state_q` three clocks later, and the response appears:

| Mode | Clocks after the loaded vector |
|---|---|
| stuck-at | one |
| launch-off-shift | two, with V2 visible after the first |
| launch-off-capture | two, with V2 visible after the first |
| no-capture | none |

Each of the three unload clocks shifts one response bit out per chain, and `done` is high in the cycle after the third. The bench advances one clock at a time, drives and samples one time unit after the rising edge, and checks each expected value in exactly the cycle worked out above. It checks `scan_en` in every cycle of a pattern, and in the done cycle it presets the back-to-back start. Expected vectors come from next-state and shift functions written from R2 and R3.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            test_mode,
  input  logic                            start,
  input  logic [1:0]                      mode,
  input  logic [NUM_CHAINS-1:0]           scan_in,
  input  logic                            func_in,
  output logic [NUM_CHAINS-1:0]           scan_out,
  output logic                            scan_en,
  output logic                            done,
  output logic [NUM_CHAINS*CHAIN_LEN-1:0] state_q
);
  localparam int W  = NUM_CHAINS * CHAIN_LEN;
  localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);
  localparam logic [1:0] M_SA = 2'b00, M_LOS = 2'b01, M_LOC = 2'b10, M_NOCAP = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LAUNCH, S_CAPT, S_UNLOAD, S_DONE} st_t;

  st_t           st;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  cells, next_d, shift_d;
  logic          clk_en;

  function automatic st_t phase_of(input logic [1:0] m);
    case (m)
      M_SA:    return S_CAPT;
      M_NOCAP: return S_UNLOAD;
      default: return S_LAUNCH;
    endcase
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_ns
    if (i == 0) begin : g_pi
      assign next_d[i] = cells[(i+W-1)%W] ^ cells[(i+2)%W] ^ func_in;
    end else begin : g_np
      assign next_d[i] = cells[(i+W-1)%W] ^ cells[(i+2)%W];
    end
  end

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
      if (k == 0) begin : g_head
        assign shift_d[c*CHAIN_LEN] = scan_in[c];
      end else begin : g_body
        assign shift_d[c*CHAIN_LEN+k] = cells[c*CHAIN_LEN+k-1];
      end
    end
    assign scan_out[c] = cells[c*CHAIN_LEN+CHAIN_LEN-1];

    if (CHAIN_LEN > 1) begin : g_chk
      p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (cells[c*CHAIN_LEN] == $past(scan_in[c])) &&
                    (cells[c*CHAIN_LEN+CHAIN_LEN-1] == $past(cells[c*CHAIN_LEN+CHAIN_LEN-2])));
    end
  end

  always_comb begin
    scan_en = 1'b0;
    clk_en  = 1'b0;
    if (!test_mode) begin
      clk_en = 1'b1;
    end else begin
      case (st)
        S_LOAD, S_UNLOAD: begin scan_en = 1'b1; clk_en = 1'b1; end
        S_LAUNCH:         begin scan_en = (mode_q == M_LOS); clk_en = 1'b1; end
        S_CAPT:           clk_en = 1'b1;
        default:          ;
      endcase
    end
  end

  assign done    = test_mode && (st == S_DONE);
  assign state_q = cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      mode_q <= M_SA;
    end else if (!test_mode) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          st     <= S_LOAD;
          cnt    <= '0;
        end
        S_LOAD: if (cnt == LAST) begin
          cnt <= '0;
          st  <= phase_of(mode_q);
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_LAUNCH: st <= S_CAPT;
        S_CAPT: begin
          st  <= S_UNLOAD;
          cnt <= '0;
        end
        S_UNLOAD: if (cnt == LAST) begin
          cnt <= '0;
          st  <= S_DONE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DONE: if (start) begin
          mode_q <= mode;
          st     <= phase_of(mode);
        end else begin
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else if (clk_en) cells <= scan_en ? shift_d : next_d;
  end

  p_func_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> cells == $past(next_d));

  p_capt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && st == S_CAPT) |=> cells == $past(next_d));

  p_los_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && st == S_LAUNCH && mode_q == M_LOS) |=> cells == $past(shift_d));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && st != S_IDLE && st != S_DONE) |=> $stable(mode_q));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cells == $past(cells));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_b2b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (st != S_LOAD && st != S_IDLE));
endmodule

// File: tb/tb_scan_seq.sv
module tb_scan_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] scan_in = 2'b00;
  logic       func_in = 1'b0;
  logic [1:0] scan_out;
  logic       scan_en;
  logic       done;
  logic [5:0] state_q;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  scan_seq dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start), .mode(mode),
    .scan_in(scan_in), .func_in(func_in), .scan_out(scan_out), .scan_en(scan_en),
    .done(done), .state_q(state_q)
  );

  always #2 clk = ~clk;

  function automatic logic [5:0] ns(input logic [5:0] v, input logic pi);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[(i+5)%6] ^ v[(i+2)%6];
    r[0] = r[0] ^ pi;
    return r;
  endfunction

  function automatic logic [5:0] shl(input logic [5:0] v, input logic [1:0] si);
    return {v[4], v[3], si[1], v[1], v[0], si[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic load_bits(input logic [5:0] v);
    for (int k = 0; k < 3; k++) begin
      chk("R3 load scan_en", {7'd0, scan_en}, 8'd1);
      chk("R3 load no done", {7'd0, done}, 8'd0);
      scan_in = {v[5-k], v[2-k]};
      tick();
    end
    chk("R3 loaded vector", {2'd0, state_q}, {2'd0, v});
  endtask

  task automatic phase_unload(input logic [1:0] m, input logic [5:0] v1,
                              input logic [1:0] lsi, input logic [5:0] w);
    logic [5:0] v2, exp;
    case (m)
      2'b00: begin
        chk("R4 capture scan_en low", {7'd0, scan_en}, 8'd0);
        tick();
        exp = ns(v1, func_in);
        chk("R4 stuck-at response", {2'd0, state_q}, {2'd0, exp});
      end
      2'b01: begin
        chk("R5 launch shift scan_en", {7'd0, scan_en}, 8'd1);
        scan_in = lsi;
        tick();
        v2 = shl(v1, lsi);
        chk("R5 V2 shifted", {2'd0, state_q}, {2'd0, v2});
        chk("R5 capture scan_en low", {7'd0, scan_en}, 8'd0);
        tick();
        exp = ns(v2, func_in);
        chk("R5 LOS response", {2'd0, state_q}, {2'd0, exp});
      end
      2'b10: begin
        chk("R6 launch scan_en low", {7'd0, scan_en}, 8'd0);
        tick();
        v2 = ns(v1, func_in);
        chk("R6 V2 functional", {2'd0, state_q}, {2'd0, v2});
        chk("R6 capture scan_en low", {7'd0, scan_en}, 8'd0);
        tick();
        exp = ns(v2, func_in);
        chk("R6 LOC response", {2'd0, state_q}, {2'd0, exp});
      end
      default: begin
        exp = v1;
        chk("R7 no capture, unload at once", {7'd0, scan_en}, 8'd1);
      end
    endcase
    for (int k = 0; k < 3; k++) begin
      chk("R9 unload scan_en", {7'd0, scan_en}, 8'd1);
      chk("R3 serial out", {6'd0, scan_out}, {6'd0, exp[5-k], exp[2-k]});
      scan_in = {w[5-k], w[2-k]};
      tick();
    end
    chk("R9 done pulse", {7'd0, done}, 8'd1);
    chk("R9 done scan_en low", {7'd0, scan_en}, 8'd0);
    chk("R10 next V1 loaded by unload", {2'd0, state_q}, {2'd0, w});
  endtask

  task automatic pattern_idle(input logic [1:0] m, input logic [5:0] v1,
                              input logic [1:0] lsi, input logic [5:0] w);
    start = 1'b1;
    mode = m;
    tick();
    start = 1'b0;
    mode = ~m;
    load_bits(v1);
    phase_unload(m, v1, lsi, w);
  endtask

  task automatic back_to_back(input logic [1:0] m, input logic [5:0] v1,
                              input logic [1:0] lsi, input logic [5:0] w);
    start = 1'b1;
    mode = m;
    tick();
    start = 1'b0;
    mode = ~m;
    chk("R10 no reload after done", {7'd0, done}, 8'd0);
    phase_unload(m, v1, lsi, w);
  endtask

  task automatic end_pattern(input logic [5:0] w);
    start = 1'b0;
    tick();
    chk("R9 done one cycle", {7'd0, done}, 8'd0);
    chk("R9 hold after done", {2'd0, state_q}, {2'd0, w});
    scan_in = 2'b11;
    tick();
    chk("R9 idle hold", {2'd0, state_q}, {2'd0, w});
    chk("R9 idle scan_en low", {7'd0, scan_en}, 8'd0);
  endtask

  task automatic test_reset;
    chk("R1 reset state", {2'd0, state_q}, 8'd0);
    chk("R1 reset scan_en", {7'd0, scan_en}, 8'd0);
    chk("R1 reset done", {7'd0, done}, 8'd0);
  endtask

  task automatic test_functional;
    logic [5:0] cur, exp;
    test_mode = 1'b0;
    start = 1'b1;
    cur = state_q;
    for (int c = 0; c < 5; c++) begin
      func_in = (c != 2);
      scan_in = 2'b11;
      chk("R2 scan_en low", {7'd0, scan_en}, 8'd0);
      chk("R2 no done", {7'd0, done}, 8'd0);
      exp = ns(cur, func_in);
      tick();
      chk("R2 functional next state", {2'd0, state_q}, {2'd0, exp});
      cur = exp;
    end
    start = 1'b0;
    test_mode = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    test_reset();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_functional();

    func_in = 1'b0;
    pattern_idle(2'b00, 6'b101_001, 2'b00, 6'b011_110);
    end_pattern(6'b011_110);

    func_in = 1'b1;
    pattern_idle(2'b01, 6'b110_010, 2'b10, 6'b100_101);
    back_to_back(2'b10, 6'b100_101, 2'b00, 6'b010_111);
    back_to_back(2'b11, 6'b010_111, 2'b00, 6'b001_100);
    back_to_back(2'b01, 6'b001_100, 2'b01, 6'b111_000);
    end_pattern(6'b111_000);

    func_in = 1'b0;
    pattern_idle(2'b10, 6'b011_011, 2'b00, 6'b000_001);
    back_to_back(2'b00, 6'b000_001, 2'b00, 6'b110_110);
    end_pattern(6'b110_110);

    pattern_idle(2'b11, 6'b100_011, 2'b00, 6'b010_010);
    end_pattern(6'b010_010);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule